// File: doc/BRIEF.md
# Peak and Valley Tracking Controller

This block is the digital half of a mixed-signal envelope detector used to slice a four-level baseband signal. It holds two codes, one for the peak of the signal and one for its valley. Each code drives an external DAC, and an external comparator on each DAC reports whether the signal has gone past that code. When the signal passes a code, the code attacks: it steps toward the signal at an attack rate. When the signal stays inside the envelope, a decay timer for that code moves it back toward the middle at a much slower rate. The block counts nothing else and adds no status.

A two-bit mode input picks fast tracking, slow tracking, hold or off. Fast and slow differ only in the attack prescale. A shared track-inhibit counter runs after every code change. While it is non-zero, attacks are ignored and the decay timers stand still. It reloads to a short value after an attack and to a long value after a decay event. All rates are counted in cycles of the single input clock.

Top module: `pv_track_ctrl`

## Requirements
- R1: A synchronous reset, active high, sets the peak code to mid-scale (128 for 8 bits), sets the valley code to mid-scale minus one (127), and clears the prescaler, the inhibit counter and both decay timers.
- R2: The mode input is encoded as 0 = off, 1 = hold, 2 = slow track and 3 = fast track. In the two tracking modes a free-running prescaler offers an attack opportunity once every FAST_DIV clocks in fast track and once every SLOW_DIV clocks in slow track.
- R3: The peak code attacks at an attack opportunity when peak_above is 1 and the inhibit counter is zero. An attack raises the peak code by one step. The valley code attacks in the same way when valley_below is 1, and an attack lowers it by one step. Any attack reloads the inhibit counter with INH_ATTACK.
- R4: Each code has its own decay timer. A timer counts one clock for each tracking clock in which the inhibit counter is zero and that code's comparator input is 0. The timer is cleared while that comparator input is 1. After DECAY_DIV counts, the timer fires. A firing peak timer lowers the peak code by one step, and a firing valley timer raises the valley code by one step. Either firing reloads the inhibit counter with INH_DECAY, even if the step is suppressed.
- R5: In the tracking modes the inhibit counter counts down by one per clock until it reaches zero. While it is non-zero, no attack happens and the decay timers do not count.
- R6: The codes saturate at 0 and 255 and never wrap.
- R7: The valley code never exceeds the peak code. A decay step that would make the valley code larger than the peak code is suppressed. When both codes decay in the same cycle, the peak step has priority.
- R8: In hold mode both codes stay frozen, and the prescaler, the inhibit counter and the decay timers keep their values.
- R9: In off mode both codes stay frozen, and the prescaler, the inhibit counter and the decay timers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every rate is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 off, 1 hold, 2 slow track, 3 fast track |
| peak_above | input | 1 | Comparator: signal is above the peak code |
| valley_below | input | 1 | Comparator: signal is below the valley code |
| peak_code | output | CODE_W | Peak code to the peak DAC |
| valley_code | output | CODE_W | Valley code to the valley DAC |

## Verification
The bench builds the block with SLOW_DIV = 4, FAST_DIV = 1, DECAY_DIV = 5, INH_ATTACK = 1 and INH_DECAY = 3, and keeps CODE_W at 8. With these values a decay event, the inhibit window that follows it and a slow-track attack each take only a few clocks. The exact clock on which each step lands can then be checked by hand. Full-scale saturation at both ends takes about 260 fast-track clocks. Meeting of the two codes, in which the valley step is suppressed, shows up within the first dozen clocks after reset.

// File: rtl/pv_pkg.sv
package pv_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_SLOW = 2'd2,
        MODE_FAST = 2'd3
    } pv_mode_e;

    localparam int TRACKERS = 2;
    localparam int IDX_PEAK = 0;
    localparam int IDX_VALLEY = 1;

endpackage

// File: rtl/pv_prescale.sv
module pv_prescale #(
    parameter int SLOW_DIV = 8,
    parameter int FAST_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic fast,
    output logic tick
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CNT_W = (MAX_DIV > 1) ? $clog2(MAX_DIV + 1) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
        tick  = 1'b0;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            if (cnt_q >= limit) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pv_inhibit.sv
module pv_inhibit #(
    parameter int INH_ATTACK = 1,
    parameter int INH_DECAY  = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic attack_ev,
    input  logic decay_ev,
    output logic expired
);
    localparam int MAX_INH = (INH_ATTACK > INH_DECAY) ? INH_ATTACK : INH_DECAY;
    localparam int CNT_W = (MAX_INH > 1) ? $clog2(MAX_INH + 1) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            if (attack_ev)       cnt_d = CNT_W'(INH_ATTACK);
            else if (decay_ev)   cnt_d = CNT_W'(INH_DECAY);
            else if (!expired)   cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pv_decay_timer.sv
module pv_decay_timer #(
    parameter int DECAY_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic gate,
    input  logic req,
    output logic fire
);
    localparam int CNT_W = (DECAY_DIV > 1) ? $clog2(DECAY_DIV + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECAY_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = 1'b0;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            if (req) begin
                cnt_d = '0;
            end else if (gate) begin
                if (cnt_q >= LAST) begin
                    fire  = 1'b1;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pv_track_ctrl.sv
module pv_track_ctrl
    import pv_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int SLOW_DIV   = 8,
    parameter int FAST_DIV   = 1,
    parameter int DECAY_DIV  = 64,
    parameter int INH_ATTACK = 1,
    parameter int INH_DECAY  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              peak_above,
    input  logic              valley_below,
    output logic [CODE_W-1:0] peak_code,
    output logic [CODE_W-1:0] valley_code
);
    localparam logic [CODE_W-1:0] CODE_MAX   = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] PEAK_INIT  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] VALLEY_INIT = PEAK_INIT - CODE_W'(1);

    typedef struct packed {
        logic [CODE_W-1:0] peak;
        logic [CODE_W-1:0] valley;
    } codes_t;

    codes_t   st_d, st_q;
    pv_mode_e mode_e;
    logic     run, clear, fast;
    logic     atk_tick, inh_expired;
    logic     pk_atk, vl_atk, pk_dec, vl_dec;
    logic     attack_ev, decay_ev;
    logic [TRACKERS-1:0] dec_req, dec_fire;
    logic [CODE_W:0] vl_raised, pk_floor;

    assign mode_e = pv_mode_e'(mode);
    assign run    = (mode_e == MODE_SLOW) || (mode_e == MODE_FAST);
    assign clear  = (mode_e == MODE_OFF);
    assign fast   = (mode_e == MODE_FAST);

    pv_prescale #(
        .SLOW_DIV(SLOW_DIV),
        .FAST_DIV(FAST_DIV)
    ) u_prescale (
        .clk(clk), .rst(rst), .run(run), .clear(clear),
        .fast(fast), .tick(atk_tick)
    );

    pv_inhibit #(
        .INH_ATTACK(INH_ATTACK),
        .INH_DECAY(INH_DECAY)
    ) u_inhibit (
        .clk(clk), .rst(rst), .run(run), .clear(clear),
        .attack_ev(attack_ev), .decay_ev(decay_ev),
        .expired(inh_expired)
    );

    assign dec_req[IDX_PEAK]   = peak_above;
    assign dec_req[IDX_VALLEY] = valley_below;

    for (genvar g = 0; g < TRACKERS; g++) begin : g_decay
        pv_decay_timer #(
            .DECAY_DIV(DECAY_DIV)
        ) u_timer (
            .clk(clk), .rst(rst), .run(run), .clear(clear),
            .gate(inh_expired), .req(dec_req[g]), .fire(dec_fire[g])
        );
    end

    always_comb begin
        pk_atk = run && atk_tick && inh_expired && peak_above
                 && (st_q.peak != CODE_MAX);
        vl_atk = run && atk_tick && inh_expired && valley_below
                 && (st_q.valley != '0);

        // peak may only decay while strictly above the valley
        pk_dec = dec_fire[IDX_PEAK] && (st_q.peak > st_q.valley);

        // valley may only rise up to the peak's value after its own step
        vl_raised = {1'b0, st_q.valley} + (CODE_W+1)'(1);
        pk_floor  = {1'b0, st_q.peak} - (CODE_W+1)'(pk_dec);
        vl_dec    = dec_fire[IDX_VALLEY] && (vl_raised <= pk_floor);

        attack_ev = pk_atk || vl_atk;
        decay_ev  = |dec_fire;

        st_d = st_q;
        if (pk_atk)      st_d.peak = st_q.peak + CODE_W'(1);
        else if (pk_dec) st_d.peak = st_q.peak - CODE_W'(1);
        if (vl_atk)      st_d.valley = st_q.valley - CODE_W'(1);
        else if (vl_dec) st_d.valley = st_q.valley + CODE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.peak   <= PEAK_INIT;
            st_q.valley <= VALLEY_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign peak_code   = st_q.peak;
    assign valley_code = st_q.valley;
endmodule

// File: rtl/pv_track_chk.sv
module pv_track_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              inh_expired,
    input logic [CODE_W-1:0] peak_code,
    input logic [CODE_W-1:0] valley_code
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    // R1: reset loads the mid-scale pair
    a_r1_reset_codes: assert property (@(posedge clk)
        rst |=> (peak_code == MID) && (valley_code == MID - CODE_W'(1)));

    // R7: ordering of the two codes
    a_r7_valley_not_above: assert property (@(posedge clk) disable iff (rst)
        valley_code <= peak_code);

    // R6: single-step moves only, so no wrap can occur
    a_r6_peak_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (peak_code == $past(peak_code))
              || (peak_code == $past(peak_code) + CODE_W'(1))
              || (peak_code == $past(peak_code) - CODE_W'(1)));

    a_r6_valley_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (valley_code == $past(valley_code))
              || (valley_code == $past(valley_code) + CODE_W'(1))
              || (valley_code == $past(valley_code) - CODE_W'(1)));

    // R8: hold freezes both codes
    a_r8_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> $stable(peak_code) && $stable(valley_code));

    // R9: off freezes both codes
    a_r9_off_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> $stable(peak_code) && $stable(valley_code));

    // R5: a running inhibit window blocks every code change
    a_r5_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
        !inh_expired |=> $stable(peak_code) && $stable(valley_code));
endmodule

bind pv_track_ctrl pv_track_chk #(.CODE_W(CODE_W)) i_pv_track_chk (
    .clk(clk),
    .rst(rst),
    .mode(mode),
    .inh_expired(inh_expired),
    .peak_code(peak_code),
    .valley_code(valley_code)
);

// File: tb/test_pv_track_ctrl.sv
`timescale 1ns/1ps
module test_pv_track_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       peak_above = 1'b0;
    logic       valley_below = 1'b0;
    logic [7:0] peak_code, valley_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pv_track_ctrl #(
        .CODE_W(8), .SLOW_DIV(4), .FAST_DIV(1), .DECAY_DIV(5),
        .INH_ATTACK(1), .INH_DECAY(3)
    ) i_pv_track_ctrl (
        .clk(clk), .rst(rst), .mode(mode),
        .peak_above(peak_above), .valley_below(valley_below),
        .peak_code(peak_code), .valley_code(valley_code)
    );

    localparam logic [1:0] M_OFF = 2'd0, M_HOLD = 2'd1, M_SLOW = 2'd2, M_FAST = 2'd3;

    // {mode, peak_above, valley_below, clocks, exp_peak, exp_valley, req}
    // applied one after another, starting right after a reset
    localparam int NV = 9;
    localparam logic [31:0] VECS [0:NV-1] = '{
        {M_SLOW, 1'b0, 1'b0, 8'd5,  8'd127, 8'd127, 4'd7}, // R7 peak decays, valley step suppressed
        {M_SLOW, 1'b0, 1'b0, 8'd8,  8'd127, 8'd127, 4'd7}, // R7 both suppressed once equal
        {M_FAST, 1'b1, 1'b1, 8'd10, 8'd131, 8'd123, 4'd5}, // R5 three blocked clocks, then attacks
        {M_SLOW, 1'b1, 1'b1, 8'd12, 8'd134, 8'd120, 4'd2}, // R2 slow: one attack per 4 clocks
        {M_HOLD, 1'b1, 1'b1, 8'd6,  8'd134, 8'd120, 4'd8}, // R8 hold ignores comparators
        {M_OFF,  1'b1, 1'b1, 8'd6,  8'd134, 8'd120, 4'd9}, // R9 off ignores comparators
        {M_FAST, 1'b0, 1'b0, 8'd5,  8'd133, 8'd121, 4'd4}, // R4 decay after 5 clocks
        {M_FAST, 1'b1, 1'b0, 8'd3,  8'd133, 8'd121, 4'd4}, // R4 decay reload blocks 3 clocks
        {M_FAST, 1'b1, 1'b0, 8'd1,  8'd134, 8'd121, 4'd3}  // R3 attack once inhibit ends
    };

    task automatic check(input string tag, input logic [7:0] ep, input logic [7:0] ev);
        n_tests++;
        if (peak_code !== ep || valley_code !== ev) begin
            n_fail++;
            $display("FAIL %s: peak=%0d valley=%0d expected peak=%0d valley=%0d",
                     tag, peak_code, valley_code, ep, ev);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic a, input logic b, input int clocks);
        mode = m;
        peak_above = a;
        valley_below = b;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mode = M_OFF;
        peak_above = 1'b0;
        valley_below = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset values", 8'd128, 8'd127);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VECS[i];
            apply(v[31:30], v[29], v[28], int'(v[27:20]));
            check($sformatf("vector %0d req R%0d", i, v[3:0]), v[19:12], v[11:4]);
        end

        // R3: attack reload of one clock gives an attack every other clock
        do_reset();
        apply(M_FAST, 1'b1, 1'b1, 1);
        check("R3 first attack", 8'd129, 8'd126);
        apply(M_FAST, 1'b1, 1'b1, 1);
        check("R3 blocked by attack reload", 8'd129, 8'd126);
        apply(M_FAST, 1'b1, 1'b1, 1);
        check("R3 second attack", 8'd130, 8'd125);

        // R6: saturation at both ends
        do_reset();
        apply(M_FAST, 1'b1, 1'b1, 260);
        check("R6 saturated", 8'd255, 8'd0);
        apply(M_FAST, 1'b1, 1'b1, 10);
        check("R6 stays saturated", 8'd255, 8'd0);

        // R8: hold keeps a partly counted decay timer
        do_reset();
        apply(M_FAST, 1'b1, 1'b1, 4);
        apply(M_SLOW, 1'b0, 1'b0, 3);
        apply(M_HOLD, 1'b0, 1'b0, 5);
        check("R8 hold frozen", 8'd130, 8'd125);
        apply(M_SLOW, 1'b0, 1'b0, 1);
        check("R8 timer resumes, not yet fired", 8'd130, 8'd125);
        apply(M_SLOW, 1'b0, 1'b0, 1);
        check("R8 decay after resumed count", 8'd129, 8'd126);

        // R9: off clears the decay timer
        do_reset();
        apply(M_FAST, 1'b1, 1'b1, 4);
        apply(M_SLOW, 1'b0, 1'b0, 3);
        apply(M_OFF, 1'b0, 1'b0, 2);
        apply(M_SLOW, 1'b0, 1'b0, 4);
        check("R9 timer restarted from zero", 8'd130, 8'd125);
        apply(M_SLOW, 1'b0, 1'b0, 1);
        check("R9 decay after full count", 8'd129, 8'd126);

        // R1: reset in mid-run restores mid-scale
        do_reset();
        check("R1 reset after activity", 8'd128, 8'd127);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule